// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM. A client raises a request together with a 6-bit word address and a phase length. The block then drives chip select, the serial clock and the data line toward the memory. It shifts out an 11-bit read command and clocks 16 data bits back in. It presents the assembled word with its two bytes exchanged, together with a one-cycle done pulse.

Every level change on the serial pins is held for a number of system clocks, so a slow memory sees settled signals. That number comes from the phase-length input and is captured when the request is accepted. A request that arrives while an access is in flight is dropped.

Top module: `eeprom_word_reader`

## Requirements
- R1: With no access running, busy_o, ee_cs_o, ee_sk_o, ee_di_o and done_o are low. A request (req_i high at a clock edge while busy_o is low) starts an access. busy_o is high from the next cycle until the last cycle before done_o.
- R2: Each pin step lasts L system clocks. L is phase_len_i sampled when the request is accepted, and a value of 0 is treated as 1.
- R3: An access begins with one step at chip select low, then one step at chip select high, both with ee_sk_o and ee_di_o low. After the last data bit it ends with one step in which all three pins are low.
- R4: The command holds 11 bits sent most significant first. Bits 10:9 are 0, bit 8 is 1 (start), bits 7:6 are 2'b10 (read), and bits 5:0 are the address.
- R5: Each command bit takes three steps with chip select high: the data line set with the clock low, then the clock high, then the clock low. The data line holds the bit across all three steps.
- R6: After the command comes one step with the data line and clock low and chip select high. Then 16 read bits follow, each a clock-high step followed by a clock-low step, with the data line low throughout.
- R7: ee_do_i is sampled only in the last system clock of each clock-high read step. The bits are assembled most significant first.
- R8: If the received 16-bit stream is W, then rdata_o = {W[7:0], W[15:8]}.
- R9: done_o is high for exactly one cycle, the cycle after the closing step ends, with rdata_o valid. rdata_o then holds until the next done_o.
- R10: A request while busy_o is high has no effect on the running access: not on its address, its phase length, or its waveform.
- R11: Asserting rst_n low at any time returns the block to the idle state of R1, with rdata_o cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a read access |
| addr_i | input | 6 | Word address of the read |
| phase_len_i | input | 8 | System clocks per pin step (0 acts as 1) |
| ee_do_i | input | 1 | Serial data from the memory |
| ee_cs_o | output | 1 | Chip select to the memory |
| ee_sk_o | output | 1 | Serial clock to the memory |
| ee_di_o | output | 1 | Serial data to the memory |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse, read word valid |
| rdata_o | output | 16 | Byte-swapped read word |

## Verification
The bench drives the memory data line to the correct bit only in the clock-high read steps and to the opposite value elsewhere. A reader that sampled at any other point would collect inverted bits and return a wrong word. A phase length of 0 is applied so that a counter that wraps instead of clamping shows up as steps 256 clocks long. An intruding request with a different address and length is raised early in an access, so a design that re-latched them would show a wrong address bit or a wrong step width. A second request is also issued in the very cycle of done and must start at once. A reset in the middle of an access must leave every pin low on the next cycle.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPEN_LO,
    PH_OPEN_HI,
    PH_CMD,
    PH_GAP,
    PH_READ,
    PH_CLOSE
  } eerd_phase_e;

  localparam int PAD_BITS = 2;
  localparam logic [1:0] OPC_READ = 2'b10;
endpackage

// File: rtl/eerd_tick.sv
module eerd_tick #(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PH_W-1:0] len_i,
  input  logic            run_i,
  output logic            tick_o
);
  logic [PH_W-1:0] len_q;
  logic [PH_W-1:0] cnt_q;

  function automatic logic [PH_W-1:0] clamp_len(input logic [PH_W-1:0] v);
    return (v == '0) ? PH_W'(1) : v;
  endfunction

  assign tick_o = run_i && (cnt_q == len_q - PH_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= PH_W'(1);
      cnt_q <= '0;
    end else begin
      if (load_i) len_q <= clamp_len(len_i);
      if (load_i || !run_i || tick_o) cnt_q <= '0;
      else cnt_q <= cnt_q + PH_W'(1);
    end
  end

  // R2
  single_tick_long_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && len_q > PH_W'(1)) |=> !tick_o);
endmodule

// File: rtl/eerd_seq.sv
module eerd_seq
  import eerd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              sample_o,
  output logic              fin_o
);
  localparam int CMD_W = PAD_BITS + 3 + ADDR_W;
  localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int IDX_W = $clog2(MAXB);
  localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(CMD_W - 1);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_W - 1);

  eerd_phase_e      phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       sub_q;
  logic [CMD_W-1:0] frame_q;

  function automatic logic [CMD_W-1:0] read_frame(input logic [ADDR_W-1:0] a);
    return {{PAD_BITS{1'b0}}, 1'b1, OPC_READ, a};
  endfunction

  assign busy_o   = (phase_q != PH_IDLE);
  assign cs_o     = (phase_q != PH_IDLE) && (phase_q != PH_OPEN_LO) && (phase_q != PH_CLOSE);
  assign sk_o     = ((phase_q == PH_CMD) && (sub_q == 2'd1)) ||
                    ((phase_q == PH_READ) && (sub_q == 2'd0));
  assign di_o     = (phase_q == PH_CMD) && frame_q[idx_q];
  assign sample_o = tick_i && (phase_q == PH_READ) && (sub_q == 2'd0);
  assign fin_o    = tick_i && (phase_q == PH_CLOSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      sub_q   <= '0;
      frame_q <= '0;
    end else if (start_i) begin
      phase_q <= PH_OPEN_LO;
      frame_q <= read_frame(addr_i);
      idx_q   <= '0;
      sub_q   <= '0;
    end else if (tick_i) begin
      case (phase_q)
        PH_OPEN_LO: phase_q <= PH_OPEN_HI;
        PH_OPEN_HI: begin
          phase_q <= PH_CMD;
          idx_q   <= CMD_LAST;
          sub_q   <= '0;
        end
        PH_CMD: begin
          if (sub_q != 2'd2) sub_q <= sub_q + 2'd1;
          else if (idx_q == '0) phase_q <= PH_GAP;
          else begin
            idx_q <= idx_q - 1'b1;
            sub_q <= '0;
          end
        end
        PH_GAP: begin
          phase_q <= PH_READ;
          idx_q   <= DATA_LAST;
          sub_q   <= '0;
        end
        PH_READ: begin
          if (sub_q == 2'd0) sub_q <= 2'd1;
          else if (idx_q == '0) phase_q <= PH_CLOSE;
          else begin
            idx_q <= idx_q - 1'b1;
            sub_q <= '0;
          end
        end
        PH_CLOSE: phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  // R10
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(frame_q));

  // R6
  read_di_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READ || phase_q == PH_GAP) |-> !di_o);
endmodule

// File: rtl/eerd_capture.sv
module eerd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              fin_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] shift_q;

  function automatic logic [DATA_W-1:0] swap_halves(input logic [DATA_W-1:0] v);
    return {v[HALF-1:0], v[DATA_W-1:HALF]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      data_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (clear_i) shift_q <= '0;
      else if (sample_i) shift_q <= {shift_q[DATA_W-2:0], bit_i};
      if (fin_i) data_o <= swap_halves(shift_q);
    end
  end

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> $stable(data_o));
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int PH_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PH_W-1:0]   phase_len_i,
  input  logic              ee_do_i,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic accept;
  logic tick;
  logic sample;
  logic fin;

  assign accept = req_i && !busy_o;

  eerd_tick #(.PH_W(PH_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .len_i  (phase_len_i),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  eerd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (accept),
    .addr_i   (addr_i),
    .tick_i   (tick),
    .busy_o   (busy_o),
    .cs_o     (ee_cs_o),
    .sk_o     (ee_sk_o),
    .di_o     (ee_di_o),
    .sample_o (sample),
    .fin_o    (fin)
  );

  eerd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .sample_i (sample),
    .bit_i    (ee_do_i),
    .fin_i    (fin),
    .done_o   (done_o),
    .data_o   (rdata_o)
  );

  // R1
  idle_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ee_cs_o && !ee_sk_o && !ee_di_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R5
  di_stable_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk_o) |-> ($stable(ee_di_o) && ee_cs_o));

  // R7
  sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (ee_sk_o && ee_cs_o));
endmodule

// File: tb/eeprom_word_reader_bench.sv
`timescale 1ns/1ps
module eeprom_word_reader_bench;
  typedef struct packed {
    logic        busy;
    logic        done;
    logic        cs;
    logic        sk;
    logic        di;
    logic        drv;
    logic [15:0] data;
    int unsigned tag;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  plen = '0;
  logic        dout = 1'b0;
  logic        cs, sk, di, busy, done;
  logic [15:0] rdata;

  ent_t        q[$];
  int          vectors = 0;
  int          fails = 0;
  int          cur_len = 1;
  logic [15:0] last_data = '0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  eeprom_word_reader u_eeprom_word_reader (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .phase_len_i(plen),
    .ee_do_i(dout), .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di),
    .busy_o(busy), .done_o(done), .rdata_o(rdata)
  );

  function automatic string tname(input int unsigned t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [15:0] mem_word(input int a);
    int v;
    v = (a * 40503) ^ 23235;
    return v[15:0];
  endfunction

  task automatic push_step(input logic c, input logic s, input logic d,
                           input logic drv, input int unsigned tag);
    ent_t e;
    e = '{busy: 1'b1, done: 1'b0, cs: c, sk: s, di: d, drv: drv, data: last_data, tag: tag};
    for (int i = 0; i < cur_len; i++) q.push_back(e);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic tick();
    ent_t  e;
    string t;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = '{busy: 1'b0, done: 1'b0, cs: 1'b0, sk: 1'b0, di: 1'b0, drv: 1'b0,
               data: last_data, tag: 1};
    vectors++;
    if ({busy, done, cs, sk, di} !== {e.busy, e.done, e.cs, e.sk, e.di}) begin
      fails++;
      $display("FAIL %s pins busy/done/cs/sk/di: actual %b expected %b",
               (e.done ? "R9" : tname(e.tag)), {busy, done, cs, sk, di},
               {e.busy, e.done, e.cs, e.sk, e.di});
    end
    if (rdata !== e.data) begin
      fails++;
      t = e.done ? "R8" : ((e.tag == 11) ? "R11" : "R9");
      $display("FAIL %s rdata: actual %h expected %h", t, rdata, e.data);
    end
    if (e.done) last_data = e.data;
    dout = e.drv;
  endtask

  // Queue up the expected waveform of one read and issue the request.
  task automatic start_read(input int a, input int len, input int unsigned ovr);
    int          frame;
    logic [15:0] w;
    logic        b;
    ent_t        fin;
    cur_len = (len == 0) ? 1 : len;
    w = mem_word(a);
    frame = 256 + 128 + a;
    push_step(1'b0, 1'b0, 1'b0, 1'b0, ovr != 0 ? ovr : 3);
    push_step(1'b1, 1'b0, 1'b0, 1'b0, ovr != 0 ? ovr : 3);
    for (int k = 10; k >= 0; k--) begin
      b = frame[k];
      push_step(1'b1, 1'b0, b, 1'b0, ovr != 0 ? ovr : 4);
      push_step(1'b1, 1'b1, b, 1'b0, ovr != 0 ? ovr : 5);
      push_step(1'b1, 1'b0, b, 1'b0, ovr != 0 ? ovr : 5);
    end
    push_step(1'b1, 1'b0, 1'b0, 1'b0, ovr != 0 ? ovr : 6);
    for (int k = 15; k >= 0; k--) begin
      push_step(1'b1, 1'b1, 1'b0, w[k], ovr != 0 ? ovr : 7);
      push_step(1'b1, 1'b0, 1'b0, ~w[k], ovr != 0 ? ovr : 6);
    end
    push_step(1'b0, 1'b0, 1'b0, 1'b0, ovr != 0 ? ovr : 3);
    fin = '{busy: 1'b0, done: 1'b1, cs: 1'b0, sk: 1'b0, di: 1'b0, drv: 1'b0,
            data: {w[7:0], w[15:8]}, tag: 9};
    q.push_back(fin);
    req  = 1'b1;
    addr = a[5:0];
    plen = len[7:0];
    tick();
    req = 1'b0;
  endtask

  task automatic drain(input int intrude_at);
    int n;
    n = 0;
    while (q.size() > 0) begin
      tick();
      // R10: an intruding request with other address and length
      if (n == intrude_at) begin
        req  = 1'b1;
        addr = ~addr;
        plen = 8'd1;
      end else begin
        req = 1'b0;
      end
      n++;
    end
    req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog: actual 200000 cycles expected completion earlier");
      finish_run();
    end
  end

  initial begin
    // R11 / R1: reset state and idle outputs
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    repeat (3) tick();

    start_read(0, 1, 0);
    drain(-1);
    tick();
    start_read(63, 3, 0);
    drain(-1);
    // R2: a phase length of 0 acts as 1
    start_read(42, 0, 2);
    drain(-1);
    // back-to-back: next request raised in the done cycle
    start_read(21, 2, 0);
    drain(-1);
    start_read(9, 1, 0);
    drain(-1);
    tick();
    // R10: request while busy is ignored
    start_read(51, 4, 10);
    drain(20);
    tick();
    // R11: reset in the middle of an access
    start_read(12, 2, 0);
    repeat (60) tick();
    q.delete();
    rst_n = 1'b0;
    last_data = '0;
    q.push_back('{busy: 1'b0, done: 1'b0, cs: 1'b0, sk: 1'b0, di: 1'b0, drv: 1'b0,
                  data: 16'h0, tag: 11});
    q.push_back('{busy: 1'b0, done: 1'b0, cs: 1'b0, sk: 1'b0, di: 1'b0, drv: 1'b0,
                  data: 16'h0, tag: 11});
    tick();
    rst_n = 1'b1;
    tick();
    start_read(37, 5, 0);
    drain(-1);
    repeat (3) tick();
    finished = 1'b1;
    finish_run();
  end
endmodule